// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block owns the 32-bit control/status word of a floating-point unit. It holds the rounding mode, the flush-to-zero control, per-exception trap enables, the cause bits of the last operation, sticky flags and eight condition codes. Software reaches the word through a control-index port. Index 31 is the full word. Indices 25, 26 and 28 are narrower views: the condition codes, the exception fields, and the enables with the mode controls. Index 0 is a fixed revision code.

After each arithmetic operation the datapath presents a six-bit status vector. The unit replaces the cause field with that vector and accumulates the sticky flags. One cycle later it raises a trap request when an enabled exception, or an unimplemented-operation condition, occurred. The rounding mode and the flush-to-zero control are driven out continuously so the datapath can use them.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the word is zero, `fp_trap` is low, `rnd_mode` is 0 and `flush_den` is 0. A read of index 31 returns 0.
- R2: A write to index 31 stores the data with bits 22:18 forced to zero. A read of index 31 returns the word, with bit 31 copied into every bus bit above 31.
- R3: A read of index 25 returns bit 23 of the word in bit 0 and bits 31:25 of the word in bits 7:1, with zeros above. A write to index 25 does the inverse mapping and changes no other bit.
- R4: Index 26 reads and writes only the cause field (bits 17:12) and the flag field (bits 6:2). Other bits read as zero and keep their values on a write.
- R5: Index 28 reads and writes only the enables (bits 11:7), the rounding mode (bits 1:0) and flush-to-zero. Flush-to-zero sits at bit 2 of this view and at bit 24 of the word.
- R6: A read of index 0 returns the parameter `REV_ID`. A read of any unmapped index returns 0. A write to index 0 or to an unmapped index changes nothing.
- R7: On a cycle with `op_done` high, the cause field becomes `op_status`. The status vector bit order is: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid, 5 unimplemented. Status bit i maps to word bit 12+i, and for i<5 to flag bit 2+i and enable bit 7+i.
- R8: A status update ORs status bits 4:0 into the flags. The unimplemented bit never sets a flag, and flags are never cleared by a status update.
- R9: `fp_trap` is high in the cycle after a status update exactly when (status bits 4:0 AND enables) is nonzero or status bit 5 is set. It is low in every other cycle.
- R10: `rnd_mode` equals word bits 1:0, where 0 means nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity. `flush_den` equals word bit 24.
- R11: When a control write and a status update occur in the same cycle, the write is applied first. The status update, and the trap test against the newly written enables, act on the result of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_widx | input | IDX_W | Control index for the write |
| cfg_wdata | input | 32 | Control write data |
| cfg_ridx | input | IDX_W | Control index for the read |
| cfg_rdata | output | XLEN | Read data, sign-extended from 32 bits |
| op_done | input | 1 | Status vector valid for one operation |
| op_status | input | 6 | Exception status of the finished operation |
| fp_trap | output | 1 | Exception request, one cycle after the update |
| rnd_mode | output | 2 | Current rounding mode |
| flush_den | output | 1 | Flush-to-zero control |

## Verification
On every cycle the assertions check four things: the reserved bits stay zero, a status update loads the cause field, the flags grow only by status bits 4:0, and the trap follows an unimplemented cause and never appears without an update. A write to the condition-code view is also checked to leave every other bit untouched. Only the bench scenarios show the bit remapping of the alias views on read and write, the sign extension, the revision code, and writes to unmapped indices being ignored. The bench also exercises write-then-update ordering when both arrive in one cycle, with the trap judged against freshly written enables.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W      = 32;
  localparam int NSTAT      = 6;
  localparam int NSTICKY    = NSTAT - 1;
  localparam int RM_LO      = 0;
  localparam int FLG_LO     = 2;
  localparam int ENA_LO     = 7;
  localparam int CAU_LO     = 12;
  localparam int FCC0_BIT   = 23;
  localparam int FS_BIT     = 24;
  localparam int FCCH_LO    = 25;
  localparam int VIEW_FS    = 2;

  localparam int IDX_REV    = 0;
  localparam int IDX_CC     = 25;
  localparam int IDX_EXC    = 26;
  localparam int IDX_ENA    = 28;
  localparam int IDX_CSR    = 31;

  localparam logic [CSR_W-1:0] MASK_ZERO  = 32'h007C_0000;
  localparam logic [CSR_W-1:0] MASK_CAUSE = 32'h0003_F000;
  localparam logic [CSR_W-1:0] MASK_FLAGS = 32'h0000_007C;
  localparam logic [CSR_W-1:0] MASK_ENA   = 32'h0000_0F80;
  localparam logic [CSR_W-1:0] MASK_RM    = 32'h0000_0003;
  localparam logic [CSR_W-1:0] MASK_FS    = 32'h0100_0000;
  localparam logic [CSR_W-1:0] MASK_FCC   = 32'hFE80_0000;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_UP      = 2'd2,
    RND_DOWN    = 2'd3
  } rnd_e;

  // Condition codes with the gap at bit 24 squeezed out.
  function automatic logic [7:0] cc_pack(input logic [CSR_W-1:0] c);
    return {c[31:FCCH_LO], c[FCC0_BIT]};
  endfunction

  function automatic logic [CSR_W-1:0] cc_unpack(input logic [7:0] v);
    logic [CSR_W-1:0] r;
    r = '0;
    r[FCC0_BIT]       = v[0];
    r[31:FCCH_LO]     = v[7:1];
    return r;
  endfunction

  function automatic logic [CSR_W-1:0] ena_view(input logic [CSR_W-1:0] c);
    logic [CSR_W-1:0] r;
    r = c & (MASK_ENA | MASK_RM);
    r[VIEW_FS] = c[FS_BIT];
    return r;
  endfunction

  function automatic logic [CSR_W-1:0] ena_unview(input logic [CSR_W-1:0] v);
    logic [CSR_W-1:0] r;
    r = v & (MASK_ENA | MASK_RM);
    r[FS_BIT] = v[VIEW_FS];
    return r;
  endfunction

  function automatic logic [CSR_W-1:0] status_apply(input logic [CSR_W-1:0] base,
                                                    input logic [NSTAT-1:0] vec);
    logic [CSR_W-1:0] r;
    r = base & ~MASK_CAUSE;
    r[CAU_LO +: NSTAT]   = vec;
    r[FLG_LO +: NSTICKY] = base[FLG_LO +: NSTICKY] | vec[NSTICKY-1:0];
    return r;
  endfunction

  function automatic logic status_trap(input logic [CSR_W-1:0] base,
                                       input logic [NSTAT-1:0] vec);
    return (|(vec[NSTICKY-1:0] & base[ENA_LO +: NSTICKY])) | vec[NSTAT-1];
  endfunction
endpackage

// File: rtl/fpcsr_wr_merge.sv
module fpcsr_wr_merge
  import fpcsr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [CSR_W-1:0] cur,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [CSR_W-1:0] wdata,
  output logic [CSR_W-1:0] merged
);
  always_comb begin
    merged = cur;
    if (we) begin
      if (idx == IDX_W'(IDX_CC))
        merged = (cur & ~MASK_FCC) | cc_unpack(wdata[7:0]);
      else if (idx == IDX_W'(IDX_EXC))
        merged = (cur & ~(MASK_CAUSE | MASK_FLAGS)) | (wdata & (MASK_CAUSE | MASK_FLAGS));
      else if (idx == IDX_W'(IDX_ENA))
        merged = (cur & ~(MASK_ENA | MASK_RM | MASK_FS)) | ena_unview(wdata);
      else if (idx == IDX_W'(IDX_CSR))
        merged = wdata & ~MASK_ZERO;
    end
  end
endmodule

// File: rtl/fpcsr_status.sv
module fpcsr_status
  import fpcsr_pkg::*;
(
  input  logic [CSR_W-1:0] base,
  input  logic             upd,
  input  logic [NSTAT-1:0] vec,
  output logic [CSR_W-1:0] next_csr,
  output logic             trap_next
);
  always_comb begin
    next_csr  = base;
    trap_next = 1'b0;
    if (upd) begin
      next_csr  = status_apply(base, vec);
      trap_next = status_trap(base, vec);
    end
  end
endmodule

// File: rtl/fpcsr_rd_view.sv
module fpcsr_rd_view
  import fpcsr_pkg::*;
#(
  parameter int              IDX_W  = 5,
  parameter int              XLEN   = 64,
  parameter logic [CSR_W-1:0] REV_ID = 32'h0000_0B27
) (
  input  logic [CSR_W-1:0] csr,
  input  logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  rdata
);
  localparam int EXT_W = XLEN - CSR_W;
  logic [CSR_W-1:0] view;

  always_comb begin
    view = '0;
    if (idx == IDX_W'(IDX_REV))      view = REV_ID;
    else if (idx == IDX_W'(IDX_CC))  view = {24'd0, cc_pack(csr)};
    else if (idx == IDX_W'(IDX_EXC)) view = csr & (MASK_CAUSE | MASK_FLAGS);
    else if (idx == IDX_W'(IDX_ENA)) view = ena_view(csr);
    else if (idx == IDX_W'(IDX_CSR)) view = csr & ~MASK_ZERO;
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign rdata = {{EXT_W{view[CSR_W-1]}}, view};
    end else begin : g_flat
      assign rdata = view;
    end
  endgenerate
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int              XLEN   = 64,
  parameter int              IDX_W  = 5,
  parameter logic [31:0]     REV_ID = 32'h0000_0B27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_widx,
  input  logic [31:0]      cfg_wdata,
  input  logic [IDX_W-1:0] cfg_ridx,
  output logic [XLEN-1:0]  cfg_rdata,
  input  logic             op_done,
  input  logic [5:0]       op_status,
  output logic             fp_trap,
  output logic [1:0]       rnd_mode,
  output logic             flush_den
);
  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] after_wr;
  logic [CSR_W-1:0] after_st;
  logic             trap_d;
  logic             trap_q;
  rnd_e             rnd_cur;

  fpcsr_wr_merge #(.IDX_W(IDX_W)) u_wr (
    .cur(csr_q), .we(cfg_we), .idx(cfg_widx), .wdata(cfg_wdata), .merged(after_wr)
  );

  fpcsr_status u_st (
    .base(after_wr), .upd(op_done), .vec(op_status),
    .next_csr(after_st), .trap_next(trap_d)
  );

  fpcsr_rd_view #(.IDX_W(IDX_W), .XLEN(XLEN), .REV_ID(REV_ID)) u_rd (
    .csr(csr_q), .idx(cfg_ridx), .rdata(cfg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      csr_q  <= after_st;
      trap_q <= trap_d;
    end
  end

  assign rnd_cur   = rnd_e'(csr_q[RM_LO +: 2]);
  assign rnd_mode  = rnd_cur;
  assign flush_den = csr_q[FS_BIT];
  assign fp_trap   = trap_q;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q & MASK_ZERO) == '0);

  assert_cause_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> csr_q[CAU_LO +: NSTAT] == $past(op_status));

  assert_sticky_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !cfg_we) |=> csr_q[FLG_LO +: NSTICKY] ==
      ($past(csr_q[FLG_LO +: NSTICKY]) | $past(op_status[NSTICKY-1:0])));

  assert_unimp_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_status[NSTAT-1]) |=> fp_trap);

  assert_trap_needs_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> !fp_trap);

  assert_cc_scope_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_widx == IDX_W'(IDX_CC) && !op_done) |=>
      (csr_q & ~MASK_FCC) == $past(csr_q & ~MASK_FCC));
endmodule

// File: tb/test_fpcsr_unit.sv
`timescale 1ns/100ps
module test_fpcsr_unit;
  localparam logic [31:0] REV = 32'h0000_0B27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_widx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  cfg_ridx = '0;
  logic [63:0] cfg_rdata;
  logic        op_done = 1'b0;
  logic [5:0]  op_status = '0;
  logic        fp_trap;
  logic [1:0]  rnd_mode;
  logic        flush_den;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 read, 1 trap, 2 rounding mode, 3 flush
    int          idx;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  fpcsr_unit #(.XLEN(64), .IDX_W(5), .REV_ID(REV)) i_fpcsr_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
    .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
    .op_done(op_done), .op_status(op_status), .fp_trap(fp_trap),
    .rnd_mode(rnd_mode), .flush_den(flush_den)
  );

  always #10 clk = ~clk;

  // Monitor: pops expectations and compares against the ports.
  initial begin
    forever begin
      item_t it;
      logic [63:0] act;
      wait (q.size() > 0);
      it = q.pop_front();
      if (it.kind == 0) cfg_ridx = 5'(it.idx);
      #1;
      case (it.kind)
        0: act = cfg_rdata;
        1: act = {63'd0, fp_trap};
        2: act = {62'd0, rnd_mode};
        default: act = {63'd0, flush_den};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                 it.tag, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input int idx, input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = 0; it.idx = idx; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_sig(input int kind, input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.idx = 0; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    #2;
  endtask

  // Driver: one cycle of write and/or status, then inputs return to idle.
  task automatic cycle(input logic we, input int widx, input logic [31:0] wd,
                       input logic sv, input logic [5:0] st);
    @(negedge clk);
    cfg_we = we; cfg_widx = 5'(widx); cfg_wdata = wd;
    op_done = sv; op_status = st;
    @(posedge clk);
    #2;
    cfg_we = 1'b0; op_done = 1'b0; op_status = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 reset state
    expect_rd(31, 64'h0, "R1 word after reset");
    expect_sig(1, 64'h0, "R1 trap after reset");
    expect_sig(2, 64'h0, "R1 rounding mode after reset");
    expect_sig(3, 64'h0, "R1 flush after reset");
    // R6 revision and unmapped read
    expect_rd(0, {32'd0, REV}, "R6 revision read");
    expect_rd(5, 64'h0, "R6 unmapped read");
    drain();

    // R2 full write, reserved zero, sign extension
    cycle(1, 31, 32'hFFFF_FFFF, 0, 6'd0);
    expect_rd(31, 64'hFFFF_FFFF_FF83_FFFF, "R2 full write masks reserved bits");
    expect_sig(2, 64'd3, "R10 rounding mode down");
    expect_sig(3, 64'd1, "R10 flush set");
    expect_rd(25, 64'h0000_0000_0000_00FF, "R3 cc view all ones");
    expect_rd(26, 64'h0000_0000_0003_F07C, "R4 exception view");
    expect_rd(28, 64'h0000_0000_0000_0F87, "R5 enables view with flush at bit 2");
    drain();

    // R3 condition-code write with gap reopened
    cycle(1, 31, 32'h0, 0, 6'd0);
    cycle(1, 25, 32'hFFFF_FFA5, 0, 6'd0);
    expect_rd(31, 64'hFFFF_FFFF_A480_0000, "R3 cc write places codes");
    expect_rd(25, 64'h0000_0000_0000_00A5, "R3 cc read closes gap");
    drain();

    // R4 exception view write touches only cause and flags
    cycle(1, 26, 32'hFFFF_FFFF, 0, 6'd0);
    expect_rd(31, 64'hFFFF_FFFF_A483_F07C, "R4 exception write scope");
    expect_rd(28, 64'h0, "R4 enables untouched");
    drain();

    // R5 enables view write
    cycle(1, 28, 32'hFFFF_FFFF, 0, 6'd0);
    expect_rd(31, 64'hFFFF_FFFF_A583_FFFF, "R5 enables write all ones");
    expect_rd(28, 64'h0000_0000_0000_0F87, "R5 enables read back");
    drain();
    cycle(1, 28, 32'h0000_0101, 0, 6'd0);
    expect_rd(31, 64'hFFFF_FFFF_A483_F17D, "R5 enables partial write");
    expect_sig(2, 64'd1, "R10 rounding mode toward zero");
    expect_sig(3, 64'd0, "R10 flush cleared");
    drain();

    // R6 writes to revision and unmapped index ignored
    cycle(1, 0, 32'hFFFF_FFFF, 0, 6'd0);
    cycle(1, 7, 32'h0000_0000, 0, 6'd0);
    expect_rd(31, 64'hFFFF_FFFF_A483_F17D, "R6 ignored writes");
    expect_rd(0, {32'd0, REV}, "R6 revision unchanged");
    drain();

    // R7/R8/R9 status updates
    cycle(1, 31, 32'h0, 0, 6'd0);
    cycle(1, 28, 32'h0000_0200, 0, 6'd0);
    cycle(0, 0, 32'h0, 1, 6'b000001);
    expect_rd(31, 64'h0000_0000_0000_1204, "R7 inexact loads cause and flag");
    expect_sig(1, 64'd0, "R9 disabled cause no trap");
    expect_rd(26, 64'h0000_0000_0000_1004, "R7 exception view after update");
    drain();
    cycle(0, 0, 32'h0, 1, 6'b000101);
    expect_rd(31, 64'h0000_0000_0000_5214, "R8 flags accumulate");
    expect_sig(1, 64'd1, "R9 enabled overflow traps");
    drain();
    cycle(0, 0, 32'h0, 0, 6'd0);
    expect_sig(1, 64'd0, "R9 trap only one cycle");
    expect_rd(31, 64'h0000_0000_0000_5214, "R7 idle keeps word");
    drain();
    cycle(0, 0, 32'h0, 1, 6'b100000);
    expect_rd(31, 64'h0000_0000_0002_0214, "R8 unimplemented sets no flag");
    expect_sig(1, 64'd1, "R9 unimplemented always traps");
    drain();
    cycle(0, 0, 32'h0, 1, 6'b000000);
    expect_rd(31, 64'h0000_0000_0000_0214, "R7 empty status clears cause");
    expect_sig(1, 64'd0, "R9 no cause no trap");
    drain();

    // R11 write and status in one cycle
    cycle(1, 26, 32'h0, 1, 6'b010000);
    expect_rd(31, 64'h0000_0000_0001_0240, "R11 write then status");
    expect_sig(1, 64'd0, "R11 invalid not enabled");
    drain();
    cycle(1, 28, 32'h0000_0800, 1, 6'b010000);
    expect_rd(31, 64'h0000_0000_0001_0840, "R11 enables write then status");
    expect_sig(1, 64'd1, "R11 trap uses new enables");
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule